// File: doc/BRIEF.md
# Expansion Interrupt and Identity Register Bank

This block sits at the front of an expansion-bay controller and gathers interrupt causes raised by its sub-units (network, disk, flash) into one 16-bit sticky status register. A 16-bit mask selects which causes drive the single interrupt request line toward the host. Besides the level request, a kick machine produces a one-cycle request pulse a programmable number of cycles after a new cause arrives, or after a mask change that touches pending causes. That pulse lets the host see the event even when the new mask hides it.

The host reaches the block through a simple register port with 8-, 16- and 32-bit accesses. Narrow accesses decode the status, the mask and four read-only identity and capability registers. Every other address, and every 32-bit access, falls through to a small plain read/write scratch store. When both the network and the disk sub-units are disabled, the register port goes dark: reads return zero and writes change nothing.

The kick machine has three states. `ST_IDLE` waits for an event and moves to `ST_COUNT` when one occurs. `ST_COUNT` counts down the delay and moves to `ST_FIRE` when the count reaches zero. `ST_FIRE` drives the pulse for one cycle. From there it returns to `ST_IDLE`, or goes back to `ST_COUNT` if a new event arrives in that cycle.

Top module: `exp_irq_bank`

## Requirements
- R1: Each nonzero bit of `cause_i` sampled at a clock edge sets the same bit of the status register. A set bit stays set until the host writes the status register.
- R2: `irq_o` is high whenever the bitwise AND of status and mask is nonzero.
- R3: A 16-bit read at byte address 0x08 returns the status register, and an 8-bit read there returns its low byte, zero-extended.
- R4: An 8- or 16-bit write at address 0x08 replaces the status with the written value, zero-extended from `bus_wdata[7:0]` or `bus_wdata[15:0]`. Cause bits arriving in the same cycle are OR-ed on top.
- R5: Only a 16-bit write at address 0x0A updates the mask, from `bus_wdata[15:0]`. 8-bit writes there are ignored. A 16-bit read there returns the mask.
- R6: A cycle with a nonzero `cause_i` arms the kick machine. So does a 16-bit mask write that changes the mask while (old mask OR new mask) AND status is nonzero. After the delay, `irq_o` is forced high for exactly one cycle.
- R7: The delay parameter `KICK_DELAY` is clamped to at least one cycle. With the default of 0, the event edge is followed by one `ST_COUNT` cycle, and the pulse is visible after the next edge.
- R8: The capability register at 0x04 reads bit 0 = `net_en` and bit 5 = 1. Bit 1, reserved for the disk, and all other bits read 0.
- R9: Identity reads give 0x0011 at 0x02 and 0x0002 at 0x0E. At 0x06 they give 0x0030 for a 16-bit read and 0x32 for an 8-bit read. Writes to these addresses are ignored.
- R10: With `net_en` and `disk_en` both low, every read returns zero and every write is ignored.
- R11: All other narrow addresses, and all 32-bit accesses at any address, use a word-organised scratch store. A 16-bit access uses bit 1 of the address to select the halfword, and an 8-bit access uses bits 1:0 to select the byte lane. Write data is taken from the low bits of `bus_wdata`, and read data is returned zero-extended in the low bits.
- R12: After reset, the status, the mask, the scratch store and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_en | input | 1 | Network sub-unit present/enabled |
| disk_en | input | 1 | Disk sub-unit present/enabled |
| cause_i | input | 16 | Per-bit interrupt cause pulses |
| bus_rd | input | 1 | Read strobe (data valid in the same cycle) |
| bus_wr | input | 1 | Write strobe (takes effect at the next edge) |
| bus_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data, low-aligned |
| bus_rdata | output | 32 | Read data, low-aligned and zero-extended |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The assertions take for granted that `bus_rd` and `bus_wr` are never high together and that addresses stay inside the 64-byte window. They also assume that `cause_i` and `rst_n` change only away from the rising edge. The stimulus drives every input on the falling edge and issues one access per cycle. During the cause and mask sweep it clears the status before each mask write, so that kick pulses appear only in the cases that check them on purpose. Enable-line changes are made only while the bus is idle.

// File: rtl/exp_irq_pkg.sv
package exp_irq_pkg;
    localparam int STAT_W = 16;

    // access sizes on bus_size
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // decoded byte addresses
    localparam logic [7:0] A_REV    = 8'h02;
    localparam logic [7:0] A_CAPS   = 8'h04;
    localparam logic [7:0] A_BAYREV = 8'h06;
    localparam logic [7:0] A_STAT   = 8'h08;
    localparam logic [7:0] A_MASK   = 8'h0A;
    localparam logic [7:0] A_FIXED  = 8'h0E;

    // identity constants
    localparam logic [15:0] REV_VAL     = 16'h0011;
    localparam logic [15:0] BAY_HALF    = 16'h0030;
    localparam logic [15:0] BAY_BYTE    = 16'h0032;
    localparam logic [15:0] FIXED_VAL   = 16'h0002;
    localparam int          CAP_NET_BIT   = 0;
    localparam int          CAP_FLASH_BIT = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } kick_st_t;
endpackage

// File: rtl/exp_irq_core.sv
module exp_irq_core
    import exp_irq_pkg::*;
#(
    parameter int KICK_DELAY = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] cause_i,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              irq_o
);
    localparam int EFF_DELAY = (KICK_DELAY < 1) ? 1 : KICK_DELAY;
    localparam int CW        = (EFF_DELAY > 1) ? $clog2(EFF_DELAY) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(EFF_DELAY - 1);

    logic [STAT_W-1:0] status_q, mask_q, status_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    kick_st_t          st_q, st_n;
    logic              mask_evt, evt, level;

    // status and mask registers
    always_comb begin
        status_n = stat_wr ? stat_wdata : status_q;
        status_n = status_n | cause_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_n;
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    assign mask_evt = mask_wr && (mask_wdata != mask_q)
                      && (((mask_q | mask_wdata) & status_q) != '0);
    assign evt      = (cause_i != '0) || mask_evt;

    // kick machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // kick machine: next state
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (evt) begin
                    st_n  = ST_COUNT;
                    cnt_n = CNT_LOAD;
                end
            end
            ST_COUNT: begin
                if (cnt_q == '0) st_n = ST_FIRE;
                else             cnt_n = cnt_q - 1'b1;
            end
            ST_FIRE: begin
                if (evt) begin
                    st_n  = ST_COUNT;
                    cnt_n = CNT_LOAD;
                end else begin
                    st_n  = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        level    = (status_q & mask_q) != '0;
        irq_o    = level || (st_q == ST_FIRE);
        status_o = status_q;
        mask_o   = mask_q;
    end

    // R1
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));
    // R1
    cause_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_i != '0) |=> ((status_q & $past(cause_i)) == $past(cause_i)));
    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));
    // R6
    fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FIRE) |=> (st_q != ST_FIRE));
    // R7
    count_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && cnt_q == '0) |=> (st_q == ST_FIRE));
endmodule

// File: rtl/exp_id_rom.sv
module exp_id_rom
    import exp_irq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic              net_en,
    output logic              hit,
    output logic [15:0]       data
);
    logic [ADDR_W-1:0] a;

    always_comb begin
        hit  = 1'b0;
        data = '0;
        a    = size[0] ? {addr[ADDR_W-1:1], 1'b0} : addr;
        if (!size[1]) begin
            if (a == ADDR_W'(A_REV)) begin
                hit  = 1'b1;
                data = REV_VAL;
            end else if (a == ADDR_W'(A_CAPS)) begin
                hit  = 1'b1;
                data[CAP_NET_BIT]   = net_en;
                data[CAP_FLASH_BIT] = 1'b1;
            end else if (a == ADDR_W'(A_BAYREV)) begin
                hit  = 1'b1;
                data = size[0] ? BAY_HALF : BAY_BYTE;
            end else if (a == ADDR_W'(A_FIXED)) begin
                hit  = 1'b1;
                data = FIXED_VAL;
            end
        end
    end
endmodule

// File: rtl/exp_scratch.sv
module exp_scratch
    import exp_irq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int WORDS = 1 << IDX_W;

    logic [31:0]      mem [WORDS];
    logic [IDX_W-1:0] widx;
    logic [4:0]       bsel, hsel;
    logic [31:0]      word;

    assign widx = addr[ADDR_W-1:2];
    assign bsel = {addr[1:0], 3'b000};
    assign hsel = {addr[1], 4'b0000};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr) begin
            case (size)
                SZ_BYTE: mem[widx][bsel +: 8]  <= wdata[7:0];
                SZ_HALF: mem[widx][hsel +: 16] <= wdata[15:0];
                default: mem[widx]             <= wdata;
            endcase
        end
    end

    always_comb begin
        word = mem[widx];
        case (size)
            SZ_BYTE: rdata = {24'h0, word[bsel +: 8]};
            SZ_HALF: rdata = {16'h0, word[hsel +: 16]};
            default: rdata = word;
        endcase
    end
endmodule

// File: rtl/exp_irq_bank.sv
module exp_irq_bank
    import exp_irq_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int KICK_DELAY = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_en,
    input  logic              disk_en,
    input  logic [15:0]       cause_i,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    logic              en, narrow, is_byte, is_half;
    logic [ADDR_W-1:0] half_addr, dec_addr;
    logic              stat_hit, mask_hit, id_hit, ram_sel;
    logic              stat_wr, mask_wr, ram_wr;
    logic [STAT_W-1:0] status, mask, stat_wdata;
    logic [15:0]       id_data;
    logic [31:0]       ram_rdata;

    assign en        = net_en | disk_en;
    assign narrow    = !bus_size[1];
    assign is_byte   = bus_size == SZ_BYTE;
    assign is_half   = bus_size == SZ_HALF;
    assign half_addr = {bus_addr[ADDR_W-1:1], 1'b0};
    assign dec_addr  = is_half ? half_addr : bus_addr;

    assign stat_hit = narrow && (dec_addr == ADDR_W'(A_STAT));
    assign mask_hit = narrow && (dec_addr == ADDR_W'(A_MASK));
    assign ram_sel  = !(stat_hit || mask_hit || id_hit);

    assign stat_wr    = en && bus_wr && stat_hit;
    assign mask_wr    = en && bus_wr && mask_hit && is_half;
    assign ram_wr     = en && bus_wr && ram_sel;
    assign stat_wdata = is_byte ? {8'h0, bus_wdata[7:0]} : bus_wdata[15:0];

    exp_id_rom #(.ADDR_W(ADDR_W)) u_id (
        .size   (bus_size),
        .addr   (bus_addr),
        .net_en (net_en),
        .hit    (id_hit),
        .data   (id_data)
    );

    exp_scratch #(.ADDR_W(ADDR_W)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ram_wr),
        .size   (bus_size),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (ram_rdata)
    );

    exp_irq_core #(.KICK_DELAY(KICK_DELAY)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause_i    (cause_i),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .mask_wr    (mask_wr),
        .mask_wdata (bus_wdata[15:0]),
        .status_o   (status),
        .mask_o     (mask),
        .irq_o      (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (en) begin
            if (stat_hit)
                bus_rdata = is_byte ? {24'h0, status[7:0]} : {16'h0, status};
            else if (mask_hit)
                bus_rdata = is_byte ? {24'h0, mask[7:0]} : {16'h0, mask};
            else if (id_hit)
                bus_rdata = is_byte ? {24'h0, id_data[7:0]} : {16'h0, id_data};
            else
                bus_rdata = ram_rdata;
        end
    end

    // R10
    dark_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!net_en && !disk_en && bus_rd) |-> (bus_rdata == '0));
    // R10
    dark_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!net_en && !disk_en && cause_i == '0) |=> $stable(status));
    // R8
    caps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bus_rd && is_half && bus_addr == ADDR_W'(A_CAPS))
        |-> (bus_rdata[0] == net_en && bus_rdata[5] && !bus_rdata[1]));
    // R2
    level_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask) != '0) |-> irq_o);
endmodule

// File: tb/test_exp_irq_bank.sv
module test_exp_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        net_en = 1'b1, disk_en = 1'b1;
    logic [15:0] cause_i = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exp_irq_bank i_exp_irq_bank (
        .clk(clk), .rst_n(rst_n), .net_en(net_en), .disk_en(disk_en),
        .cause_i(cause_i), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic rd(input logic [1:0] sz, input logic [5:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_size = sz; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sz, input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_cause(input logic [15:0] c);
        cause_i = c;
        @(negedge clk);
        cause_i = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            nerr++; nvec++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 irq", {31'h0, irq_o}, 32'h0);
        rd(2'd1, 6'h08, d); chk("R12 status", d, 32'h0);
        rd(2'd1, 6'h0A, d); chk("R12 mask", d, 32'h0);
        rd(2'd2, 6'h10, d); chk("R12 scratch", d, 32'h0);

        // R9 identity and R8 capability
        rd(2'd1, 6'h02, d); chk("R9 rev16", d, 32'h0011);
        rd(2'd0, 6'h02, d); chk("R9 rev8", d, 32'h0011);
        rd(2'd1, 6'h06, d); chk("R9 bay16", d, 32'h0030);
        rd(2'd0, 6'h06, d); chk("R9 bay8", d, 32'h0032);
        rd(2'd1, 6'h0E, d); chk("R9 fixed", d, 32'h0002);
        wr(2'd1, 6'h02, 32'h0000_BEEF);
        rd(2'd1, 6'h02, d); chk("R9 readonly", d, 32'h0011);
        rd(2'd1, 6'h04, d); chk("R8 caps both", d, 32'h0021);
        net_en = 1'b0; @(negedge clk);
        rd(2'd1, 6'h04, d); chk("R8 caps disk only", d, 32'h0020);
        net_en = 1'b1; disk_en = 1'b0; @(negedge clk);
        rd(2'd0, 6'h04, d); chk("R8 caps net only", d, 32'h0021);
        disk_en = 1'b1; @(negedge clk);

        // R1 R2 R3 sweep: cause bit i against mask bit j
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                wr(2'd0, 6'h08, 32'h0);
                wr(2'd1, 6'h0A, 32'h1 << j);
                pulse_cause(16'h1 << i);
                chk("R2 level", {31'h0, irq_o}, (i == j) ? 32'h1 : 32'h0);
                rd(2'd1, 6'h08, d); chk("R1 R3 status16", d, 32'h1 << i);
                rd(2'd0, 6'h08, d); chk("R3 status8", d, (i < 8) ? (32'h1 << i) : 32'h0);
                idle(2);
            end
        end

        // R1 accumulation and stickiness
        wr(2'd0, 6'h08, 32'h0);
        wr(2'd1, 6'h0A, 32'h0);
        pulse_cause(16'h0003);
        pulse_cause(16'h8000);
        idle(4);
        rd(2'd1, 6'h08, d); chk("R1 sticky", d, 32'h8003);

        // R4 writes overwrite, same-cycle cause ORs on top
        wr(2'd1, 6'h08, 32'hFFFF_1234);
        rd(2'd1, 6'h08, d); chk("R4 write16", d, 32'h1234);
        cause_i = 16'h0100;
        wr(2'd0, 6'h08, 32'h0000_AB80);
        cause_i = '0;
        rd(2'd1, 6'h08, d); chk("R4 write8 plus cause", d, 32'h0180);
        idle(3);

        // R5 mask: 8-bit write ignored
        wr(2'd0, 6'h08, 32'h0);
        wr(2'd1, 6'h0A, 32'h00F0);
        wr(2'd0, 6'h0A, 32'h0000_0011);
        rd(2'd1, 6'h0A, d); chk("R5 byte ignored", d, 32'h00F0);
        rd(2'd0, 6'h0A, d); chk("R5 mask8", d, 32'h00F0);

        // R6 R7 mask-change kick with one-cycle minimum delay
        wr(2'd1, 6'h0A, 32'h0001);
        pulse_cause(16'h0001);
        idle(4);
        chk("R2 unmasked level", {31'h0, irq_o}, 32'h1);
        wr(2'd1, 6'h0A, 32'h0000);       // edge k: evt
        chk("R7 count cycle", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R6 kick pulse", {31'h0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R6 pulse ends", {31'h0, irq_o}, 32'h0);
        idle(2);
        wr(2'd1, 6'h0A, 32'h0000);       // unchanged mask: no kick
        chk("R6 same mask a", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R6 same mask b", {31'h0, irq_o}, 32'h0);
        wr(2'd1, 6'h0A, 32'h0002);       // change but no pending overlap
        chk("R6 no overlap a", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R6 no overlap b", {31'h0, irq_o}, 32'h0);
        pulse_cause(16'h0004);           // masked cause still kicks
        chk("R7 cause count", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R6 cause kick", {31'h0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R6 cause kick ends", {31'h0, irq_o}, 32'h0);

        // R11 scratch store lanes and 32-bit fall-through
        wr(2'd2, 6'h10, 32'hA1B2_C3D4);
        rd(2'd0, 6'h10, d); chk("R11 byte0", d, 32'hD4);
        rd(2'd0, 6'h13, d); chk("R11 byte3", d, 32'hA1);
        rd(2'd1, 6'h12, d); chk("R11 half1", d, 32'hA1B2);
        wr(2'd0, 6'h11, 32'h0000_0055);
        wr(2'd1, 6'h12, 32'h0000_7788);
        rd(2'd2, 6'h10, d); chk("R11 merged", d, 32'h7788_55D4);
        rd(2'd1, 6'h08, d);
        begin
            logic [31:0] st;
            st = d;
            wr(2'd2, 6'h08, 32'h1357_9BDF);
            rd(2'd2, 6'h08, d); chk("R11 word at status addr", d, 32'h1357_9BDF);
            rd(2'd1, 6'h08, d); chk("R11 status untouched", d, st);
        end
        wr(2'd0, 6'h09, 32'h0000_0066);
        rd(2'd0, 6'h09, d); chk("R11 odd byte", d, 32'h66);

        // R10 disabled port
        wr(2'd1, 6'h0A, 32'h0003);
        net_en = 1'b0; disk_en = 1'b0; @(negedge clk);
        rd(2'd1, 6'h02, d); chk("R10 id dark", d, 32'h0);
        rd(2'd1, 6'h0A, d); chk("R10 mask dark", d, 32'h0);
        wr(2'd1, 6'h0A, 32'h00FF);
        wr(2'd1, 6'h08, 32'hFFFF);
        wr(2'd2, 6'h10, 32'h0);
        net_en = 1'b1; @(negedge clk);
        rd(2'd1, 6'h0A, d); chk("R10 mask kept", d, 32'h0003);
        rd(2'd1, 6'h08, d); chk("R10 status kept", d, 32'h0005);
        rd(2'd2, 6'h10, d); chk("R10 scratch kept", d, 32'h7788_55D4);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule